// File: doc/BRIEF.md
# Serial Adapter Status and Interrupt Unit

This unit holds the 8-bit status byte of an asynchronous serial adapter and decides when the adapter requests processor attention. It receives single-cycle events from the receive and transmit paths: one when a received word moves into the receive holding register, and one when the transmit holding register is handed to the shifter. It also takes the receiver's parity and framing results and two active-low modem inputs, carrier present and set ready. It takes host strobes for a status read, a receive data read, a transmit data write and a program reset, and the command bits that gate interrupts.

Receive and transmit interrupts are raised on events and stay pending until the status byte is read. Modem-line activity is handled differently. The first change of either line freezes both line bits at the new level and raises an interrupt. Further activity is ignored until the host reads status. After that read, the line is compared again, and if it still differs from the frozen level a fresh interrupt follows at once. A program reset clears the overrun flag and withdraws an interrupt that came only from the modem lines. An interrupt that came from the data paths stays pending until it is serviced. The interrupt output is a pull-low enable for a shared open-drain line.

Top module: `acia_stat_top`

## Requirements
- R1: After hardware reset the status byte reads 0x10 (only transmit-empty, bit 4, set) with both modem inputs low, and `irqPullLow` is 0; bits 6 and 5 mirror the inputs after a two-clock synchronizer.
- R2: A receive transfer event sets bit 3 and loads bit 0 (parity error) and bit 1 (framing error) from the receiver inputs in the same clock; a receive data read clears bits 3, 1 and 0.
- R3: A receive transfer while bit 3 is still set (and no read in that cycle) sets bit 2 (overrun) and keeps bits 1 and 0 of the held word; bit 2 clears on a receive data read or a program reset.
- R4: A transmit transfer event sets bit 4 and a transmit data write clears it; when both occur in one cycle the write wins and bit 4 is 0.
- R5: A receive transfer raises bit 7 on the next clock only when master enable is 1 and receive-interrupt-off is 0.
- R6: A transmit transfer raises bit 7 only when master enable is 1 and the transmit interrupt mode is 2'b01; modes 00, 10 and 11 raise nothing.
- R7: A status read clears bit 7 on the next clock, unless an enabled receive or transmit event arrives in the same cycle, in which case bit 7 stays 1.
- R8: With master enable 1, a change of the synchronized level of either modem line (bit 6 = set-ready line, bit 5 = carrier line, 1 = high) raises bit 7 and freezes bits 6 and 5 at the new level; later line changes alter neither bit until a status read.
- R9: The clock after a status read, bits 6 and 5 show the current lines again; if they differ from the frozen level, bit 7 is raised again on the following clock.
- R10: A program reset drops an interrupt caused only by a modem line on the next clock, but leaves a pending receive or transmit interrupt set.
- R11: With master enable 0, modem-line changes raise no interrupt and bits 6 and 5 follow the synchronized inputs.
- R12: `irqPullLow` equals bit 7 of the status byte at every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| rxXferEvt | input | 1 | Received word moved into the receive holding register |
| txXferEvt | input | 1 | Transmit holding register handed to the shifter |
| rxParErr | input | 1 | Parity error of the word being transferred |
| rxFrmErr | input | 1 | Framing error of the word being transferred |
| dcdLineN | input | 1 | Carrier-present modem input, active low, asynchronous |
| dsrLineN | input | 1 | Set-ready modem input, active low, asynchronous |
| cmdMasterEn | input | 1 | Master interrupt enable command bit |
| cmdRxIrqOff | input | 1 | Receive interrupt disable command bit |
| cmdTxMode | input | 2 | Transmit interrupt mode; 2'b01 enables the transmit interrupt |
| statusRd | input | 1 | Host reads the status byte |
| rxDataRd | input | 1 | Host reads the receive holding register |
| txDataWr | input | 1 | Host writes the transmit holding register |
| progReset | input | 1 | Program reset strobe |
| statusByte | output | 8 | Status byte: 7 irq, 6 set-ready, 5 carrier, 4 tx empty, 3 rx full, 2 overrun, 1 framing, 0 parity |
| irqPullLow | output | 1 | Enable for pulling the shared interrupt line low |

## Verification
The bench targets the modem freeze window. A design that tracks the lines while frozen would show a second change without an interrupt. A design that does not re-compare after the status read would lose the change that arrived while frozen. It drives same-cycle collisions: a status read against an enabled receive event, where a wrong priority drops a real interrupt, and a write against a transmit transfer, where a wrong priority reports an empty register that is full. It checks overrun on a second transfer, where a design that overwrote the error bits would report the wrong word's errors. It checks that a program reset withdraws only modem-caused interrupts, where a design that cleared everything would lose pending data service.

// File: rtl/acia_stat_pkg.sv
package acia_stat_pkg;
  localparam int MODEM_W = 2;
  localparam logic [1:0] TX_IRQ_ON = 2'b01;

  typedef struct packed {
    logic rxRead;
    logic txWrite;
    logic ovrClear;
  } dpStrobes_t;
endpackage

// File: rtl/acia_stat_datapath.sv
module acia_stat_datapath
  import acia_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strobes,
  input  logic               rxXferEvt,
  input  logic               txXferEvt,
  input  logic               rxParErr,
  input  logic               rxFrmErr,
  input  logic [MODEM_W-1:0] modemLinesN,
  output logic               rxFull,
  output logic               txEmpty,
  output logic               overrun,
  output logic               frmErr,
  output logic               parErr,
  output logic [MODEM_W-1:0] modemSync
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][MODEM_W-1:0] syncPipe;
  logic accepting;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '1;
    end else begin
      syncPipe[0] <= modemLinesN;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end
  assign modemSync = syncPipe[LAST];

  assign accepting = ~rxFull | strobes.rxRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull  <= 1'b0;
      txEmpty <= 1'b1;
      overrun <= 1'b0;
      frmErr  <= 1'b0;
      parErr  <= 1'b0;
    end else begin
      if (rxXferEvt) rxFull <= 1'b1;
      else if (strobes.rxRead) rxFull <= 1'b0;

      if (strobes.txWrite) txEmpty <= 1'b0;
      else if (txXferEvt) txEmpty <= 1'b1;

      if (rxXferEvt && accepting) begin
        frmErr <= rxFrmErr;
        parErr <= rxParErr;
      end else if (strobes.rxRead) begin
        frmErr <= 1'b0;
        parErr <= 1'b0;
      end

      if (rxXferEvt && !accepting) overrun <= 1'b1;
      else if (strobes.ovrClear) overrun <= 1'b0;
    end
  end

  // R2
  rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rxRead && !rxXferEvt |=> !rxFull && !frmErr && !parErr);

  // R3
  overrun_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxXferEvt && rxFull && !strobes.rxRead |=> overrun && rxFull && $stable(frmErr) && $stable(parErr));

  // R4
  tx_write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txWrite |=> !txEmpty);
endmodule

// File: rtl/acia_stat_ctrl.sv
module acia_stat_ctrl
  import acia_stat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               statusRd,
  input  logic               rxDataRd,
  input  logic               txDataWr,
  input  logic               progReset,
  input  logic               rxXferEvt,
  input  logic               txXferEvt,
  input  logic               cmdMasterEn,
  input  logic               cmdRxIrqOff,
  input  logic [1:0]         cmdTxMode,
  input  logic [MODEM_W-1:0] modemSync,
  output dpStrobes_t         strobes,
  output logic               irqFlag,
  output logic [MODEM_W-1:0] modemShow
);
  logic rxIrqEn, txIrqEn, dataSet, modemChg;
  logic irqData, irqModem, modemLock;
  logic [MODEM_W-1:0] modemLat;

  assign strobes.rxRead   = rxDataRd;
  assign strobes.txWrite  = txDataWr;
  assign strobes.ovrClear = rxDataRd | progReset;

  always_comb begin
    rxIrqEn  = cmdMasterEn & ~cmdRxIrqOff;
    txIrqEn  = cmdMasterEn & (cmdTxMode == TX_IRQ_ON);
    dataSet  = (rxXferEvt & rxIrqEn) | (txXferEvt & txIrqEn);
    modemChg = ~modemLock & cmdMasterEn & ~progReset & (modemSync != modemLat);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqData   <= 1'b0;
      irqModem  <= 1'b0;
      modemLock <= 1'b0;
      modemLat  <= '1;
    end else begin
      irqData   <= dataSet | (irqData & ~statusRd);
      irqModem  <= modemChg | (irqModem & ~statusRd & ~progReset);
      modemLock <= modemChg | (modemLock & ~statusRd & ~progReset);
      if (!modemLock) modemLat <= modemSync;
    end
  end

  assign modemShow = modemLock ? modemLat : modemSync;
  assign irqFlag   = irqData | irqModem;

  // R7
  status_read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusRd && modemLock && !rxXferEvt && !txXferEvt |=> !irqFlag);

  // R8
  modem_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    modemLock && !statusRd && !progReset |=> $stable(modemShow) && irqFlag);

  // R10
  prog_reset_modem_chk: assert property (@(posedge clk) disable iff (!rstN)
    progReset && !irqData && !rxXferEvt && !txXferEvt |=> !irqFlag);

  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdMasterEn && !irqFlag |=> !irqFlag);
endmodule

// File: rtl/acia_stat_top.sv
module acia_stat_top
  import acia_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxXferEvt,
  input  logic       txXferEvt,
  input  logic       rxParErr,
  input  logic       rxFrmErr,
  input  logic       dcdLineN,
  input  logic       dsrLineN,
  input  logic       cmdMasterEn,
  input  logic       cmdRxIrqOff,
  input  logic [1:0] cmdTxMode,
  input  logic       statusRd,
  input  logic       rxDataRd,
  input  logic       txDataWr,
  input  logic       progReset,
  output logic [7:0] statusByte,
  output logic       irqPullLow
);
  dpStrobes_t strobes;
  logic rxFull, txEmpty, overrun, frmErr, parErr, irqFlag;
  logic [MODEM_W-1:0] modemSync, modemShow;

  acia_stat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .statusRd(statusRd), .rxDataRd(rxDataRd),
    .txDataWr(txDataWr), .progReset(progReset), .rxXferEvt(rxXferEvt),
    .txXferEvt(txXferEvt), .cmdMasterEn(cmdMasterEn), .cmdRxIrqOff(cmdRxIrqOff),
    .cmdTxMode(cmdTxMode), .modemSync(modemSync), .strobes(strobes),
    .irqFlag(irqFlag), .modemShow(modemShow)
  );

  acia_stat_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rxXferEvt(rxXferEvt),
    .txXferEvt(txXferEvt), .rxParErr(rxParErr), .rxFrmErr(rxFrmErr),
    .modemLinesN({dsrLineN, dcdLineN}), .rxFull(rxFull), .txEmpty(txEmpty),
    .overrun(overrun), .frmErr(frmErr), .parErr(parErr), .modemSync(modemSync)
  );

  assign statusByte = {irqFlag, modemShow[1], modemShow[0], txEmpty, rxFull, overrun, frmErr, parErr};
  assign irqPullLow = irqFlag;
endmodule

// File: tb/acia_stat_top_test.sv
`timescale 1ns/1ps
module acia_stat_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxXferEvt = 0, txXferEvt = 0, rxParErr = 0, rxFrmErr = 0;
  logic dcdLineN = 0, dsrLineN = 0;
  logic cmdMasterEn = 0, cmdRxIrqOff = 0;
  logic [1:0] cmdTxMode = 2'b00;
  logic statusRd = 0, rxDataRd = 0, txDataWr = 0, progReset = 0;
  logic [7:0] statusByte;
  logic irqPullLow;

  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  acia_stat_top uut (
    .clk(clk), .rstN(rstN), .rxXferEvt(rxXferEvt), .txXferEvt(txXferEvt),
    .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .dcdLineN(dcdLineN), .dsrLineN(dsrLineN),
    .cmdMasterEn(cmdMasterEn), .cmdRxIrqOff(cmdRxIrqOff), .cmdTxMode(cmdTxMode),
    .statusRd(statusRd), .rxDataRd(rxDataRd), .txDataWr(txDataWr), .progReset(progReset),
    .statusByte(statusByte), .irqPullLow(irqPullLow)
  );

  // reference model built from the requirements
  logic [1:0] mS0, mS1, mLat;
  logic mLock, mIrqA, mIrqM, mFull, mTxE, mOvr, mFe, mPe;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS0 <= 2'b11; mS1 <= 2'b11; mLat <= 2'b11; mLock <= 0;
      mIrqA <= 0; mIrqM <= 0; mFull <= 0; mTxE <= 1; mOvr <= 0; mFe <= 0; mPe <= 0;
    end else begin
      logic rxEn, txEn, effFull, chg;
      rxEn = cmdMasterEn & ~cmdRxIrqOff;
      txEn = cmdMasterEn & (cmdTxMode == 2'b01);
      effFull = mFull & ~rxDataRd;
      chg = ~mLock & cmdMasterEn & ~progReset & (mS1 != mLat);
      mS0 <= {dsrLineN, dcdLineN};
      mS1 <= mS0;
      if (!mLock) mLat <= mS1;
      mLock <= chg | (mLock & ~statusRd & ~progReset);
      mIrqM <= chg | (mIrqM & ~statusRd & ~progReset);
      mIrqA <= (rxXferEvt & rxEn) | (txXferEvt & txEn) | (mIrqA & ~statusRd);
      mFull <= rxXferEvt ? 1'b1 : (rxDataRd ? 1'b0 : mFull);
      mTxE  <= txDataWr ? 1'b0 : (txXferEvt ? 1'b1 : mTxE);
      if (rxXferEvt && effFull) mOvr <= 1'b1;
      else if (rxDataRd || progReset) mOvr <= 1'b0;
      if (rxXferEvt && !effFull) begin mFe <= rxFrmErr; mPe <= rxParErr; end
      else if (rxDataRd) begin mFe <= 0; mPe <= 0; end
    end
  end

  function automatic logic [7:0] modelByte();
    logic [1:0] show;
    show = mLock ? mLat : mS1;
    return {mIrqA | mIrqM, show[1], show[0], mTxE, mFull, mOvr, mFe, mPe};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmpModel();
    logic [7:0] e;
    e = modelByte();
    chk("R7 irq bit", {7'd0, statusByte[7]}, {7'd0, e[7]});
    chk("R8 modem bits", {6'd0, statusByte[6:5]}, {6'd0, e[6:5]});
    chk("R4 tx empty", {7'd0, statusByte[4]}, {7'd0, e[4]});
    chk("R2 rx full", {7'd0, statusByte[3]}, {7'd0, e[3]});
    chk("R3 overrun", {7'd0, statusByte[2]}, {7'd0, e[2]});
    chk("R2 error bits", {6'd0, statusByte[1:0]}, {6'd0, e[1:0]});
    chk("R12 pull-low", {7'd0, irqPullLow}, {7'd0, statusByte[7]});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmpModel();
  endtask

  task automatic clearStrobes();
    rxXferEvt = 0; txXferEvt = 0; statusRd = 0; rxDataRd = 0; txDataWr = 0; progReset = 0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    rstN = 1;
    repeat (3) tick();
    // R1
    chk("R1 reset byte", statusByte, 8'h10);
    chk("R1 reset pull-low", {7'd0, irqPullLow}, 8'h00);

    cmdMasterEn = 1; cmdRxIrqOff = 0; cmdTxMode = 2'b00;
    rxXferEvt = 1; rxParErr = 1; rxFrmErr = 0; tick(); clearStrobes();
    chk("R2 R5 first word", statusByte, 8'h99);
    rxXferEvt = 1; rxParErr = 0; rxFrmErr = 1; tick(); clearStrobes();
    chk("R3 overrun keeps errors", statusByte, 8'h9D);
    statusRd = 1; tick(); clearStrobes();
    chk("R7 status read", statusByte, 8'h1D);
    rxDataRd = 1; tick(); clearStrobes();
    chk("R2 R3 data read", statusByte, 8'h10);

    txDataWr = 1; tick(); clearStrobes();
    chk("R4 write clears", statusByte, 8'h00);
    txXferEvt = 1; tick(); clearStrobes();
    chk("R6 mode 00 silent", statusByte, 8'h10);
    txDataWr = 1; tick(); clearStrobes();
    cmdTxMode = 2'b11; txXferEvt = 1; tick(); clearStrobes();
    chk("R6 mode 11 silent", statusByte, 8'h10);
    txDataWr = 1; tick(); clearStrobes();
    cmdTxMode = 2'b01; txXferEvt = 1; tick(); clearStrobes();
    chk("R6 mode 01 raises", statusByte, 8'h90);
    statusRd = 1; tick(); clearStrobes();

    cmdRxIrqOff = 1; rxXferEvt = 1; rxParErr = 0; rxFrmErr = 0; tick(); clearStrobes();
    chk("R5 rx irq off", statusByte, 8'h18);
    rxDataRd = 1; tick(); clearStrobes();
    cmdRxIrqOff = 0; cmdTxMode = 2'b00;

    dcdLineN = 1; repeat (4) tick();
    chk("R8 carrier change", statusByte, 8'hB0);
    dcdLineN = 0; repeat (4) tick();
    chk("R8 frozen level", statusByte, 8'hB0);
    statusRd = 1; tick(); clearStrobes();
    chk("R9 after read", statusByte, 8'h10);
    tick();
    chk("R9 re-raise", statusByte, 8'h90);
    statusRd = 1; tick(); clearStrobes();
    tick();
    chk("R9 settled", statusByte, 8'h10);

    dsrLineN = 1; repeat (4) tick();
    chk("R8 set-ready change", statusByte, 8'hD0);
    progReset = 1; cmdMasterEn = 0; tick(); clearStrobes();
    chk("R10 modem irq dropped", statusByte, 8'h50);
    chk("R10 pull-low released", {7'd0, irqPullLow}, 8'h00);

    cmdMasterEn = 1; tick();
    rxXferEvt = 1; tick(); clearStrobes();
    rxXferEvt = 1; tick(); clearStrobes();
    chk("R3 overrun again", statusByte, 8'hDC);
    progReset = 1; cmdMasterEn = 0; tick(); clearStrobes();
    chk("R10 R3 data irq kept", statusByte, 8'hD8);
    statusRd = 1; tick(); clearStrobes();
    rxDataRd = 1; tick(); clearStrobes();
    chk("R10 serviced", statusByte, 8'h50);

    dsrLineN = 0; repeat (4) tick();
    chk("R11 disabled follows", statusByte, 8'h10);

    cmdMasterEn = 1; tick();
    rxXferEvt = 1; statusRd = 1; tick(); clearStrobes();
    chk("R7 set beats read", statusByte, 8'h98);
    txDataWr = 1; txXferEvt = 1; tick(); clearStrobes();
    chk("R4 write beats transfer", statusByte, 8'h88);
    statusRd = 1; rxDataRd = 1; tick(); clearStrobes();
    chk("R7 R2 cleanup", statusByte, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      clearStrobes();
      rxXferEvt = ($urandom % 8) == 0;
      txXferEvt = ($urandom % 8) == 0;
      rxParErr  = $urandom % 2;
      rxFrmErr  = $urandom % 2;
      statusRd  = ($urandom % 6) == 0;
      rxDataRd  = ($urandom % 7) == 0;
      txDataWr  = ($urandom % 7) == 0;
      if (($urandom % 40) == 0) dcdLineN = ~dcdLineN;
      if (($urandom % 45) == 0) dsrLineN = ~dsrLineN;
      if (($urandom % 30) == 0) begin
        cmdMasterEn = $urandom % 4 != 0;
        cmdRxIrqOff = $urandom % 2;
        cmdTxMode   = 2'($urandom % 4);
      end
      if (($urandom % 120) == 0) begin
        progReset = 1; cmdMasterEn = 0; cmdRxIrqOff = 0; cmdTxMode = 2'b00;
      end
      tick();
    end
    clearStrobes();
    tick();
    finishRun();
  end
endmodule